// File: doc/BRIEF.md
# I2C Start Reservation Controller

This block decides how an I2C master obtains the bus. When software asks for a start, the block checks whether the bus is free. If it is free, the block asks the pin driver for a start condition at once. If it is busy, the block holds the request as a reservation and does not touch the lines. When the reservation later sees a stop condition, it issues the start without further help from software and parks the master in a wait state.

The block samples SCL and SDA to find start and stop conditions and keeps a bus-busy flag from them. While the master is parked after a start, a write to the transmit data register begins the address byte. Software can tell whether its request became a start or a reservation. It does this by reading the master-status output once a settling flag rises. The length of the settling wait follows the transfer-clock selection. Arbitration loss and a release command both return the controller to idle. Neither one causes a retry.

Top module: `i2c_start_reserve`

## Requirements
- R1: `bus_busy` is 0 after reset. It goes to 1 when SDA falls while SCL is high, and to 0 when SDA rises while SCL is high. It is visible two cycles after the line change. SDA edges while SCL is low leave it unchanged.
- R2: A `start_req` pulse while `bus_busy` is 0 gives a one-cycle `gen_start` pulse in the next cycle. In that same cycle `master_sts` and `wait_state` go to 1 and `reserved` stays 0.
- R3: A `start_req` pulse while `bus_busy` is 1 and `stop_irq_en` is 1 sets `reserved` in the next cycle. It gives no `gen_start`, and `master_sts` stays 0.
- R4: A `start_req` pulse while `bus_busy` is 1 and `stop_irq_en` is 0 is ignored. No reservation is made and no start is issued, even after the next stop.
- R5: While `reserved` is 1, a stop condition gives `gen_start` for one cycle, two cycles after the SDA rise. In that cycle `master_sts` and `wait_state` are 1 and `reserved` is 0.
- R6: A `tx_write` pulse while `wait_state` is 1 gives a one-cycle `addr_xfer` pulse in the next cycle and clears `wait_state`. At any other time `tx_write` gives no `addr_xfer`.
- R7: A `release_req` pulse clears `reserved`, `master_sts` and `wait_state` in the next cycle. A cancelled reservation issues no start at the next stop.
- R8: A `start_req` while `reserved` is 1 is ignored. The reservation stays and the settling wait is not restarted.
- R9: An `arb_lost` pulse while `master_sts` is 1 clears `master_sts` in the next cycle. No start is retried at later stops.
- R10: `sts_valid` is 0 after reset. It drops when a start request is accepted (either a start or a reservation). It rises exactly 4 << `clk_sel` cycles after the cycle in which the request was sampled: `clk_sel` = 0, 1, 2, 3 gives 4, 8, 16, 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| start_req | input | 1 | Software start request, one-cycle pulse |
| release_req | input | 1 | Software release/cancel command, pulse |
| tx_write | input | 1 | Transmit data register written, pulse |
| arb_lost | input | 1 | Arbitration loss from the bit engine, pulse |
| stop_irq_en | input | 1 | Stop-condition interrupt enable; required for reservations |
| clk_sel | input | 2 | Transfer-clock selection; sets the settling wait |
| bus_busy | output | 1 | Bus is between a start and a stop |
| gen_start | output | 1 | One-cycle request to drive a start condition |
| master_sts | output | 1 | Device is bus master |
| wait_state | output | 1 | Master parked after start, waiting for data |
| reserved | output | 1 | Start reservation pending |
| addr_xfer | output | 1 | One-cycle launch of the address byte |
| sts_valid | output | 1 | Settling wait elapsed; master status may be read |

## Verification
Every control output is registered. A command pulse driven in one cycle shows its effect in the next cycle. Line events pass through two sampling stages, so busy changes and reservation-triggered starts appear two cycles after the SDA change. The settling flag rises 4 << `clk_sel` cycles after the request cycle. For each stimulus, the scoreboard records the exact due cycle with a mask of the outputs that matter. The monitor compares only in that cycle, at the falling clock edge. A wrong latency therefore shows up as a mismatch.

// File: rtl/i2c_rsv_pkg.sv
package i2c_rsv_pkg;

    localparam int CSEL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RSV   = 2'd1,
        ST_MWAIT = 2'd2,
        ST_MXFER = 2'd3
    } rsv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_s;

    typedef struct packed {
        logic stop_det;
        logic busy;
    } bus_evt_s;

    function automatic int unsigned settle_len(int unsigned base, logic [CSEL_W-1:0] sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/i2c_rsv_bus_mon.sv
module i2c_rsv_bus_mon
    import i2c_rsv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_s evt
);
    line_s cur_q, old_q;
    logic  busy_q;
    logic  start_det, stop_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '{scl: 1'b1, sda: 1'b1};
            old_q  <= '{scl: 1'b1, sda: 1'b1};
            busy_q <= 1'b0;
        end else begin
            cur_q <= '{scl: scl_in, sda: sda_in};
            old_q <= cur_q;
            if (start_det)
                busy_q <= 1'b1;
            else if (stop_det)
                busy_q <= 1'b0;
        end
    end

    // Conditions: SDA edge while SCL stays high across both samples
    assign start_det = old_q.scl & cur_q.scl & old_q.sda & ~cur_q.sda;
    assign stop_det  = old_q.scl & cur_q.scl & ~old_q.sda & cur_q.sda;

    assign evt = '{stop_det: stop_det, busy: busy_q};

    p_busy_set_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(start_det));
    p_busy_clr_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(stop_det));

endmodule

// File: rtl/i2c_rsv_ctrl.sv
module i2c_rsv_ctrl
    import i2c_rsv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_s evt,
    input  logic     start_req,
    input  logic     release_req,
    input  logic     tx_write,
    input  logic     arb_lost,
    input  logic     stop_irq_en,
    output logic     gen_start,
    output logic     master_sts,
    output logic     wait_state,
    output logic     reserved,
    output logic     addr_xfer,
    output logic     req_taken
);
    rsv_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            gen_start <= 1'b0;
            addr_xfer <= 1'b0;
        end else begin
            gen_start <= 1'b0;
            addr_xfer <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        if (!evt.busy) begin
                            state_q   <= ST_MWAIT;
                            gen_start <= 1'b1;
                        end else if (stop_irq_en) begin
                            state_q <= ST_RSV;
                        end
                    end
                end
                ST_RSV: begin
                    if (release_req) begin
                        state_q <= ST_IDLE;
                    end else if (evt.stop_det) begin
                        state_q   <= ST_MWAIT;
                        gen_start <= 1'b1;
                    end
                end
                ST_MWAIT: begin
                    if (arb_lost || release_req) begin
                        state_q <= ST_IDLE;
                    end else if (tx_write) begin
                        state_q   <= ST_MXFER;
                        addr_xfer <= 1'b1;
                    end
                end
                ST_MXFER: begin
                    if (arb_lost || release_req || evt.stop_det)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign reserved   = (state_q == ST_RSV);
    assign wait_state = (state_q == ST_MWAIT);
    assign master_sts = (state_q == ST_MWAIT) || (state_q == ST_MXFER);
    assign req_taken  = (state_q == ST_IDLE) && start_req && (!evt.busy || stop_irq_en);

    p_rsv_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        reserved |-> !gen_start && !master_sts);
    p_auto_start_r5: assert property (@(posedge clk) disable iff (rst)
        reserved && evt.stop_det && !release_req |=> gen_start && wait_state);
    p_addr_wait_r6: assert property (@(posedge clk) disable iff (rst)
        addr_xfer |-> $past(wait_state) && $past(tx_write));
    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        release_req |=> !reserved && !master_sts);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        reserved && start_req && !release_req && !evt.stop_det |=> reserved);
    p_arb_drop_r9: assert property (@(posedge clk) disable iff (rst)
        master_sts && arb_lost |=> !master_sts && !gen_start);

endmodule

// File: rtl/i2c_rsv_settle.sv
module i2c_rsv_settle
    import i2c_rsv_pkg::*;
#(
    parameter int unsigned SETTLE_BASE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_taken,
    input  logic [CSEL_W-1:0] clk_sel,
    output logic              sts_valid
);
    localparam int unsigned MAX_WAIT = SETTLE_BASE << ((1 << CSEL_W) - 1);
    localparam int          CNT_W    = $clog2(MAX_WAIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            sts_valid <= 1'b0;
        end else if (req_taken) begin
            cnt_q     <= CNT_W'(settle_len(SETTLE_BASE, clk_sel));
            sts_valid <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1))
                sts_valid <= 1'b1;
        end
    end

    p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_valid) |-> $past(cnt_q) == CNT_W'(1));
    p_valid_drop_r10: assert property (@(posedge clk) disable iff (rst)
        req_taken |=> !sts_valid);

endmodule

// File: rtl/i2c_start_reserve.sv
module i2c_start_reserve
    import i2c_rsv_pkg::*;
#(
    parameter int unsigned SETTLE_BASE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              start_req,
    input  logic              release_req,
    input  logic              tx_write,
    input  logic              arb_lost,
    input  logic              stop_irq_en,
    input  logic [CSEL_W-1:0] clk_sel,
    output logic              bus_busy,
    output logic              gen_start,
    output logic              master_sts,
    output logic              wait_state,
    output logic              reserved,
    output logic              addr_xfer,
    output logic              sts_valid
);
    bus_evt_s evt;
    logic     req_taken;

    i2c_rsv_bus_mon u_mon (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_rsv_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .start_req   (start_req),
        .release_req (release_req),
        .tx_write    (tx_write),
        .arb_lost    (arb_lost),
        .stop_irq_en (stop_irq_en),
        .gen_start   (gen_start),
        .master_sts  (master_sts),
        .wait_state  (wait_state),
        .reserved    (reserved),
        .addr_xfer   (addr_xfer),
        .req_taken   (req_taken)
    );

    i2c_rsv_settle #(.SETTLE_BASE(SETTLE_BASE)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .req_taken (req_taken),
        .clk_sel   (clk_sel),
        .sts_valid (sts_valid)
    );

    assign bus_busy = evt.busy;

    p_no_drive_busy_r2: assert property (@(posedge clk) disable iff (rst)
        gen_start |-> master_sts);

endmodule

// File: tb/test_i2c_start_reserve.sv
module test_i2c_start_reserve;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       start_req = 1'b0, release_req = 1'b0, tx_write = 1'b0, arb_lost = 1'b0;
    logic       stop_irq_en = 1'b1;
    logic [1:0] clk_sel = 2'd0;
    logic       bus_busy, gen_start, master_sts, wait_state, reserved, addr_xfer, sts_valid;

    i2c_start_reserve i_i2c_start_reserve (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .start_req(start_req), .release_req(release_req), .tx_write(tx_write),
        .arb_lost(arb_lost), .stop_irq_en(stop_irq_en), .clk_sel(clk_sel),
        .bus_busy(bus_busy), .gen_start(gen_start), .master_sts(master_sts),
        .wait_state(wait_state), .reserved(reserved), .addr_xfer(addr_xfer),
        .sts_valid(sts_valid)
    );

    localparam logic [6:0] BSY = 7'b1000000, GEN = 7'b0100000, MST = 7'b0010000,
                           WT  = 7'b0001000, RSV = 7'b0000100, ADR = 7'b0000010,
                           VAL = 7'b0000001, ALL = 7'b1111111;

    logic [6:0] obs;
    assign obs = {bus_busy, gen_start, master_sts, wait_state, reserved, addr_xfer, sts_valid};

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         due;
        logic [6:0] mask;
        logic [6:0] exp;
        string      req;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;

    task automatic expect_at(int dly, logic [6:0] m, logic [6:0] e, string r);
        item_t it;
        it.due  = cyc + dly;
        it.mask = m;
        it.exp  = e & m;
        it.req  = r;
        sb.push_back(it);
    endtask

    // Monitor: compares every item due in this cycle, away from the clock edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                checks++;
                if ((obs & sb[i].mask) !== sb[i].exp) begin
                    errors++;
                    $display("FAIL %s: cycle %0d outputs=%b expected=%b (mask %b)",
                             sb[i].req, cyc, obs & sb[i].mask, sb[i].exp, sb[i].mask);
                end
                sb.delete(i);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        summary();
    end

    initial begin
        tick();
        expect_at(0, ALL, 7'b0, "R1 R10 reset");
        tick(2);
        rst = 1'b0;
        tick(2);

        // R2 immediate start on a free bus, R10 settle with clk_sel=0 (4 cycles)
        start_req = 1'b1;
        expect_at(1, GEN|MST|WT|RSV|VAL, GEN|MST|WT, "R2");
        expect_at(2, GEN, 7'b0, "R2");
        expect_at(4, VAL, 7'b0, "R10");
        expect_at(5, VAL, VAL, "R10");
        tick(); start_req = 1'b0;
        tick(5);

        // R6 address launch from the wait state
        tx_write = 1'b1;
        expect_at(1, ADR|WT|MST, ADR|MST, "R6");
        expect_at(2, ADR, 7'b0, "R6");
        tick(); tx_write = 1'b0;
        tick(2);
        tx_write = 1'b1;
        expect_at(1, ADR|MST, MST, "R6 outside wait");
        tick(); tx_write = 1'b0;
        tick();

        // R7 release leaves master
        release_req = 1'b1;
        expect_at(1, MST|WT|RSV, 7'b0, "R7");
        tick(); release_req = 1'b0;
        tick();
        tx_write = 1'b1;
        expect_at(1, ADR, 7'b0, "R6 idle");
        tick(); tx_write = 1'b0;
        tick();

        // R1 SDA edges with SCL low do nothing
        scl_in = 1'b0; tick();
        sda_in = 1'b0; expect_at(2, BSY, 7'b0, "R1 scl low"); tick();
        sda_in = 1'b1; expect_at(2, BSY, 7'b0, "R1 scl low"); tick();
        scl_in = 1'b1; expect_at(2, BSY, 7'b0, "R1 scl low"); tick(3);

        // R1 start on bus sets busy two cycles later
        sda_in = 1'b0;
        expect_at(1, BSY, 7'b0, "R1");
        expect_at(2, BSY, BSY, "R1");
        tick(3);

        // R3 reservation, R10 settle with clk_sel=2 (16 cycles)
        clk_sel = 2'd2;
        start_req = 1'b1;
        expect_at(1, GEN|MST|WT|RSV|VAL, RSV, "R3");
        expect_at(16, VAL, 7'b0, "R10");
        expect_at(17, VAL, VAL, "R8 R10 no restart");
        tick(); start_req = 1'b0;
        tick(2);
        // R8 request while reserved is ignored
        start_req = 1'b1;
        expect_at(1, RSV|GEN|MST, RSV, "R8");
        tick(); start_req = 1'b0;
        tick(16);

        // R5 stop fires the reserved start
        sda_in = 1'b1;
        expect_at(1, GEN|RSV, RSV, "R5");
        expect_at(2, BSY|GEN|MST|WT|RSV, GEN|MST|WT, "R5 R1");
        expect_at(3, GEN, 7'b0, "R5");
        tick(4);

        // R9 arbitration loss, no retry
        arb_lost = 1'b1;
        expect_at(1, MST|WT|RSV, 7'b0, "R9");
        tick(); arb_lost = 1'b0;
        tick();
        sda_in = 1'b0; tick(3);
        sda_in = 1'b1;
        expect_at(2, GEN|MST, 7'b0, "R9 no retry");
        tick(4);

        // R4 no reservation without stop interrupt enable
        stop_irq_en = 1'b0;
        sda_in = 1'b0; tick(3);
        start_req = 1'b1;
        expect_at(1, RSV|GEN|MST, 7'b0, "R4");
        tick(); start_req = 1'b0;
        tick();
        sda_in = 1'b1;
        expect_at(2, GEN|MST, 7'b0, "R4");
        tick(4);

        // R7 cancel a reservation, R10 with clk_sel=3 (32 cycles)
        stop_irq_en = 1'b1;
        clk_sel = 2'd3;
        sda_in = 1'b0; tick(3);
        start_req = 1'b1;
        expect_at(1, RSV, RSV, "R7 setup");
        expect_at(32, VAL, 7'b0, "R10");
        expect_at(33, VAL, VAL, "R10");
        tick(); start_req = 1'b0;
        tick();
        release_req = 1'b1;
        expect_at(1, RSV, 7'b0, "R7");
        tick(); release_req = 1'b0;
        tick();
        sda_in = 1'b1;
        expect_at(2, GEN|MST, 7'b0, "R7 cancelled");
        tick(36);

        if (sb.size() != 0) begin
            errors += sb.size();
            $display("FAIL scoreboard: %0d items pending, expected 0", sb.size());
        end
        summary();
    end

endmodule